// File: doc/BRIEF.md
# Cascadable Serial Configuration Bitstream Reader

This block is the read side of a bit-serial configuration store that feeds a programmable logic device loading itself in master serial mode. It holds a bit array of `DEPTH` single-bit locations. The loading device supplies the configuration clock, and on each rising edge the block moves to the next bit. The bit being presented appears on a three-state data line, modelled here as a value output and an enable output.

Several copies can be chained into one long bitstream. The cascade output of each copy drives the chip enable of the next. When one copy has sent its last bit, it releases its data line and lowers its cascade output, and the following copy takes over on the very next clock. A combined reset/output-enable pin has a polarity chosen at power-on. A power-on sequencer holds an open-drain ready indicator low for a fixed number of reference-clock cycles. A parallel preload port fills the array.

Top module: `cfg_bitstream_reader`

## Requirements
- R1: `ready_low` (1 means the ready pin is pulled low) is 1 while `por` is high and for `POR_CYCLES` rising `ref_clk` edges after `por` falls, then becomes 0 and stays 0 until the next `por`.
- R2: `data_oe` is 1 only when `ser_en` is 1, `ce_n` is 0, `rst_oe` is at its enable level, `ready_low` is 0 and the last bit has not yet been sent; otherwise the line is released.
- R3: While `data_oe` is 1, each rising `cclk` edge advances the read position by one, and `data_o` shows the preloaded bit at the current position, starting from position 0.
- R4: A `cclk` edge with `rst_oe` at its reset level (and `ser_en` 1) returns the read position to 0 and clears the completion state, whatever `ce_n` is; on an edge where a reset and the last-bit advance coincide, the reset wins.
- R5: `pol_sel` is captured on `ref_clk` only while `por` is high: captured 1 makes `rst_oe`=1 the reset level, captured 0 makes `rst_oe`=0 the reset level; changes of `pol_sel` after `por` have no effect.
- R6: While `ce_n` is 1 (and `rst_oe` is not at its reset level), the read position does not move and `data_oe` is 0.
- R7: On the `cclk` edge that consumes the last bit (position `DEPTH`-1), `ceo_n` goes to 0 and `data_oe` goes to 0 in the same step.
- R8: After the last bit, while `rst_oe` stays at its enable level, `ceo_n` follows `ce_n`; once `rst_oe` reaches its reset level, `ceo_n` is 1 and stays 1 until all `DEPTH` bits have been read again.
- R9: While `ser_en` is 0, `data_oe` is 0, `ceo_n` is 1, and `ce_n`, `rst_oe` and `cclk` leave the read position unchanged.
- R10: Two copies chained `ceo_n` to `ce_n` produce the first array followed by the second on one shared line, one bit per clock, with exactly one driver per bit and no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock for power-on timing, polarity capture and preload |
| por | input | 1 | Power-on reset, active high, asynchronous |
| pol_sel | input | 1 | Reset polarity selection, captured while `por` is high |
| pre_we | input | 1 | Preload write strobe (on `ref_clk`) |
| pre_addr | input | $clog2(DEPTH) | Preload bit position |
| pre_bit | input | 1 | Preload bit value |
| cclk | input | 1 | Configuration clock from the loading device |
| ce_n | input | 1 | Chip enable, active low |
| rst_oe | input | 1 | Combined reset / output enable, polarity per R5 |
| ser_en | input | 1 | 1 = configuration read mode, 0 = programming mode |
| data_o | output | 1 | Serial data value (0 when not driven) |
| data_oe | output | 1 | Data line driver enable |
| ceo_n | output | 1 | Cascade chip enable output, active low |
| ready_low | output | 1 | 1 = ready pin pulled low (power-on cycle in progress) |

## Verification
The consumption of the last bit and a counter reset can fall on the same `cclk` edge. The bench walks one copy up to position `DEPTH`-1 and raises `rst_oe` to its reset level just before that edge. After the edge it expects `ceo_n` still high, and after the release it expects the first bit shown again, not a handoff. A second overlap is the cascade handoff itself, where one copy releases the line and its neighbour begins driving on the same edge. A scoreboard judges this by requiring exactly one enable per sampled bit and the expected bit value at every position of the joined stream.

// File: rtl/cfg_bitstream_reader.sv
module cfg_bitstream_reader #(
  parameter int DEPTH      = 256,
  parameter int POR_CYCLES = 16,
  localparam int AW        = $clog2(DEPTH),
  localparam int CW        = $clog2(POR_CYCLES + 1)
) (
  input  logic          ref_clk,
  input  logic          por,
  input  logic          pol_sel,
  input  logic          pre_we,
  input  logic [AW-1:0] pre_addr,
  input  logic          pre_bit,
  input  logic          cclk,
  input  logic          ce_n,
  input  logic          rst_oe,
  input  logic          ser_en,
  output logic          data_o,
  output logic          data_oe,
  output logic          ceo_n,
  output logic          ready_low
);

  logic [DEPTH-1:0] mem;
  logic             pol_q;
  logic [CW-1:0]    por_cnt;
  logic [AW-1:0]    addr;
  logic             done;
  logic             rst_lvl, rd_on, sel;

  always_ff @(posedge ref_clk)
    if (pre_we) mem[pre_addr] <= pre_bit;

  always_ff @(posedge ref_clk)
    if (por) pol_q <= pol_sel;

  always_ff @(posedge ref_clk or posedge por)
    if (por)                            por_cnt <= '0;
    else if (por_cnt != CW'(POR_CYCLES)) por_cnt <= por_cnt + 1'b1;

  assign ready_low = (por_cnt != CW'(POR_CYCLES));
  assign rst_lvl   = pol_q ? rst_oe : ~rst_oe;
  assign rd_on     = ser_en & ~ready_low;
  assign sel       = rd_on & ~ce_n;

  always_ff @(posedge cclk or posedge por)
    if (por) begin
      addr <= '0;
      done <= 1'b0;
    end else if (ready_low || (ser_en && rst_lvl)) begin
      addr <= '0;
      done <= 1'b0;
    end else if (sel && !done) begin
      if (addr == AW'(DEPTH - 1)) done <= 1'b1;
      else                        addr <= addr + 1'b1;
    end

  assign data_oe = sel & ~rst_lvl & ~done;
  assign data_o  = data_oe & mem[addr];
  assign ceo_n   = ~(rd_on & done & ~rst_lvl & ~ce_n);

endmodule

// File: rtl/cfg_bitstream_reader_chk.sv
module cfg_bitstream_reader_chk #(
  parameter int AW = 8
) (
  input logic          cclk,
  input logic          ref_clk,
  input logic          por,
  input logic          ce_n,
  input logic          rst_oe,
  input logic          ser_en,
  input logic          data_oe,
  input logic          ceo_n,
  input logic          ready_low,
  input logic          done,
  input logic [AW-1:0] addr,
  input logic          pol_q
);

  logic rl;
  assign rl = pol_q ? rst_oe : !rst_oe;

  AST_READY_STAYS: assert property (@(posedge ref_clk) disable iff (por)
    !ready_low |=> !ready_low); // R1

  AST_OE_GATED: assert property (@(posedge cclk) disable iff (por)
    data_oe |-> (ser_en && !ce_n && !ready_low && !rl)); // R2

  AST_ADVANCE: assert property (@(posedge cclk) disable iff (por)
    (data_oe && ser_en) |=> ((addr == $past(addr) + 1'b1) || done)); // R3

  AST_CE_FREEZE: assert property (@(posedge cclk) disable iff (por)
    (ce_n && !rl && !ready_low) |=> $stable(addr)); // R6

  AST_HANDOFF_EXCL: assert property (@(posedge cclk) disable iff (por)
    !ceo_n |-> !data_oe); // R7

  AST_SER_OFF: assert property (@(posedge cclk) disable iff (por)
    !ser_en |-> (ceo_n && !data_oe)); // R9

  AST_SER_FREEZE: assert property (@(posedge cclk) disable iff (por)
    (!ser_en && !ready_low) |=> $stable(addr)); // R9

endmodule

bind cfg_bitstream_reader cfg_bitstream_reader_chk #(.AW(AW)) u_chk (.*);

// File: tb/test_cfg_bitstream_reader.sv
`timescale 1ns/1ps
module test_cfg_bitstream_reader;
  localparam int DEPTH = 16;
  localparam int PORC  = 5;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic por = 1'b1, pol_sel = 1'b1, pre_we = 1'b0, pre_a = 1'b0, pre_b = 1'b0;
  logic [AW-1:0] pre_addr = '0;
  logic con_n = 1'b1, rst_oe = 1'b0, ser_en = 1'b1;
  logic dA, oeA, ceoA, rdyA, dB, oeB, ceoB, rdyB;

  cfg_bitstream_reader #(.DEPTH(DEPTH), .POR_CYCLES(PORC)) i_cfg_bitstream_reader (
    .ref_clk(clk), .por(por), .pol_sel(pol_sel), .pre_we(pre_we), .pre_addr(pre_addr),
    .pre_bit(pre_a), .cclk(clk), .ce_n(con_n), .rst_oe(rst_oe), .ser_en(ser_en),
    .data_o(dA), .data_oe(oeA), .ceo_n(ceoA), .ready_low(rdyA));

  cfg_bitstream_reader #(.DEPTH(DEPTH), .POR_CYCLES(PORC)) i_cfg_bitstream_reader_b (
    .ref_clk(clk), .por(por), .pol_sel(pol_sel), .pre_we(pre_we), .pre_addr(pre_addr),
    .pre_bit(pre_b), .cclk(clk), .ce_n(ceoA), .rst_oe(rst_oe), .ser_en(ser_en),
    .data_o(dB), .data_oe(oeB), .ceo_n(ceoB), .ready_low(rdyB));

  int checks = 0, errors = 0;
  bit mon_en = 1'b0, finished = 1'b0;
  logic exp_q[$];
  logic [DEPTH-1:0] memA, memB;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // scoreboard monitor: one expected bit per sampled cycle on the joined line
  always @(negedge clk) begin
    if (mon_en) begin
      logic b;
      chk($countones({oeA, oeB}), 1, "R10 single driver per bit");
      b = oeA ? dA : dB;
      if (exp_q.size() == 0) chk(1, 0, "R10 stream longer than expected");
      else chk(b, exp_q.pop_front(), "R10 stream bit");
    end
  end

  initial begin
    #(20 * 100000);
    chk(0, 1, "watchdog expired");
    report();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      memA[i] = ((i * 7 + 3) % 5) < 2;
      memB[i] = (i % 3) != 1;
    end
    step(1);
    for (int i = 0; i < DEPTH; i++) begin
      pre_addr = AW'(i); pre_a = memA[i]; pre_b = memB[i]; pre_we = 1'b1;
      step(1);
    end
    pre_we = 1'b0;
    #3;
    chk(rdyA, 1, "R1 ready held low during por");
    chk(oeA | oeB, 0, "R2 no drive during por");
    chk(ceoA, 1, "R8 ceo high at reset");

    por = 1'b0;
    step(PORC - 1); #3;
    chk(rdyA, 1, "R1 still low one cycle before end");
    step(1); #3;
    chk(rdyA, 0, "R1 released after POR_CYCLES");
    chk(rdyB, 0, "R1 second copy released");

    // cascade stream R10 / R3 / R7
    for (int i = 0; i < DEPTH; i++) exp_q.push_back(memA[i]);
    for (int i = 0; i < DEPTH; i++) exp_q.push_back(memB[i]);
    con_n = 1'b0; mon_en = 1'b1;
    wait (exp_q.size() == 0);
    step(1); mon_en = 1'b0; #3;
    chk(ceoA, 0, "R7 first copy ceo low after last bit");
    chk(oeA, 0, "R7 first copy released");
    chk(ceoB, 0, "R7 second copy ceo low after last bit");
    chk(oeB, 0, "R7 second copy released");

    // R8 follow CE, then OE reset returns high
    con_n = 1'b1; #3;
    chk(ceoA, 1, "R8 ceo follows ce high");
    con_n = 1'b0; #3;
    chk(ceoA, 0, "R8 ceo follows ce low");
    rst_oe = 1'b1; #3;
    chk(oeA, 0, "R2 reset level blocks drive");
    step(1); rst_oe = 1'b0; #3;
    chk(ceoA, 1, "R8 ceo high after reset level");
    chk(oeA, 1, "R4 restart enabled");
    chk(dA, memA[0], "R4 restart at bit 0");

    // R3 / R6 freeze
    step(3); #3;
    chk(dA, memA[3], "R3 advance to bit 3");
    con_n = 1'b1; #3;
    chk(oeA, 0, "R6 released while ce high");
    step(4); con_n = 1'b0; #3;
    chk(dA, memA[3], "R6 position frozen while ce high");

    // R4 reset while CE high
    con_n = 1'b1; rst_oe = 1'b1;
    step(1); rst_oe = 1'b0; con_n = 1'b0; #3;
    chk(dA, memA[0], "R4 reset applies with ce high");

    // R4 reset coinciding with last-bit edge
    step(DEPTH - 1); #3;
    chk(dA, memA[DEPTH-1], "R3 last bit shown");
    chk(ceoA, 1, "R7 ceo high before last edge");
    rst_oe = 1'b1;
    step(1); rst_oe = 1'b0; #3;
    chk(ceoA, 1, "R4 reset wins over completion");
    chk(oeA, 1, "R4 still driving after coincident reset");
    chk(dA, memA[0], "R4 back to bit 0 after coincident reset");

    // R9 programming mode
    step(2); #3;
    chk(dA, memA[2], "R3 at bit 2");
    ser_en = 1'b0; #3;
    chk(oeA, 0, "R9 no drive in programming mode");
    chk(ceoA, 1, "R9 ceo high in programming mode");
    rst_oe = 1'b1;
    step(3); rst_oe = 1'b0; ser_en = 1'b1; #3;
    chk(dA, memA[2], "R9 position kept through programming mode");

    // R5 inverted polarity
    con_n = 1'b1; por = 1'b1; pol_sel = 1'b0;
    step(2); por = 1'b0; pol_sel = 1'b1;
    step(PORC); #3;
    chk(rdyA, 0, "R1 released after second por");
    con_n = 1'b0; #3;
    chk(oeA, 0, "R5 rst_oe low is reset level");
    rst_oe = 1'b1; #3;
    chk(oeA, 1, "R5 rst_oe high enables");
    chk(dA, memA[0], "R5 starts at bit 0");
    step(2); #3;
    chk(dA, memA[2], "R5 advancing with inverted polarity");
    rst_oe = 1'b0;
    step(1); rst_oe = 1'b1; #3;
    chk(dA, memA[0], "R5 low level cleared position");

    report();
  end
endmodule